// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the state of a bank of interrupt sources and turns interrupt events into delivery offers for an interrupt presenter. Each source carries a target server number, an 8-bit priority (all ones means masked) and three flags: masked-pending, resend-needed and a level input that reports whether the source is still asserted. A single sequencer makes one delivery attempt at a time. It sends an offer, waits for the presenter's reply, and then does one of three things: it records a refusal for later retry, it retries at once, or it starts a new attempt for a source that the presenter displaced.

Events come in one per cycle: a trigger for a source, an end-of-interrupt, or a configuration write that unmasks a source. Each is turned into a source number and placed in a short FIFO. A resend request from the presenter names a server. The block atomically takes and clears that server's per-group resend bits. It then scans the named groups in ascending source order and redelivers every source whose resend flag is set. Source numbers are `{group, slot}`, with the group in bit 3 and the slot in bits 2:0 for the default 2 groups of 8.

Top module: `irq_src_bank`

## Requirements
- R1: After reset every source has priority 0xFF (masked), all flags and resend bitmaps are clear, and no offer is made.
- R2: A delivery attempt on an unmasked source drives `offer_valid` for exactly one cycle, with the source number, its priority and its server. The sequencer then waits for `rep_valid` before it does anything else.
- R3: An attempt on a source whose priority is 0xFF makes no offer and sets the source's masked-pending flag. This holds for first deliveries and for resends alike, so the interrupt is kept.
- R4: A configuration write with a priority other than 0xFF to a source whose masked-pending flag is set clears the flag and queues a delivery. A write to a source without the flag queues nothing.
- R5: A refusal (`rep_valid` with `rep_accept` low) sets the source's resend flag and sets bit `group` in the resend bitmap of the source's server.
- R6: A refusal that arrives with `rep_need_resend` low is followed by a new attempt for the same source in the next cycle.
- R7: `rs_req` takes and clears the bitmap of `rs_server`. The sequencer then walks all sources in ascending order and redelivers each one whose group bit was taken and whose resend flag is set.
- R8: Every delivery attempt clears the source's resend flag when it starts.
- R9: An acceptance with `rep_disp_valid` high and `rep_disp_ipi` low starts a new attempt for `rep_disp_src` in the next cycle. A displaced source marked as an IPI is dropped.
- R10: An end-of-interrupt for a source whose `level_in` bit is high queues a redelivery of that source. If the bit is low, nothing is queued.
- R11: Queued sources are delivered in arrival order, one attempt at a time. Queued work is taken before a pending resend scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src | input | 4 | Source being configured |
| cfg_prio | input | 8 | New priority (0xFF = masked) |
| cfg_server | input | 2 | New target server |
| trig_valid | input | 1 | Interrupt event strobe |
| trig_src | input | 4 | Source raising the event |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_src | input | 4 | Source being completed |
| level_in | input | 16 | Asserted state of each level source |
| rs_req | input | 1 | Resend request from a presenter |
| rs_server | input | 2 | Server whose bitmap is taken |
| rep_valid | input | 1 | Presenter reply strobe |
| rep_accept | input | 1 | Offer accepted |
| rep_need_resend | input | 1 | Presenter's need-resend flag at the time of the reply |
| rep_disp_valid | input | 1 | Acceptance displaced a pending source |
| rep_disp_ipi | input | 1 | The displaced item is an IPI |
| rep_disp_src | input | 4 | Displaced source number |
| offer_valid | output | 1 | Delivery offer strobe |
| offer_src | output | 4 | Offered source |
| offer_prio | output | 8 | Priority of the offered source |
| offer_server | output | 2 | Target server of the offered source |

## Verification
The bench aims at the refusal paths. Getting the need-resend qualifier backwards would either lose a refused source or loop, and the immediate retry is what leaves a bitmap bit set with no flagged source behind it, so a later scan must produce no offer. Masking a source between its refusal and the resend scan checks that the scan parks the source as masked-pending and does not drop it: unmasking must bring the offer back. The bench also checks that an IPI displacement is ignored while a real one is chased, that end-of-interrupt follows the level input, and that a resend request for the wrong server or a repeated one finds nothing.

// File: rtl/isc_pkg.sv
`timescale 1ns/1ps
// Shared constants and sequencer state encoding for the interrupt source bank.
package isc_pkg;
    localparam int PRIO_W = 8;
    localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SCAN = 2'd1,
        SQ_ATT  = 2'd2,
        SQ_WAIT = 2'd3
    } sq_state_t;
endpackage

// File: rtl/isc_fifo.sv
`timescale 1ns/1ps
// Small FIFO of source numbers waiting for a delivery attempt.
// Assumes the producer does not push when full; such a push is dropped.
module isc_fifo #(
    parameter int W     = 4,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] rp_q, wp_q;
    logic [AW:0]   cnt_q;
    logic wr, rd;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == (AW+1)'(DEPTH));
    assign wr    = push && !full;
    assign rd    = pop && !empty;
    assign dout  = mem[rp_q];

    // Storage write, no reset needed on the data.
    always_ff @(posedge clk) begin
        if (wr) mem[wp_q] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_q  <= '0;
            wp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
            if (rd) rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
            case ({wr, rd})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/isc_state.sv
`timescale 1ns/1ps
// Per-source configuration and flags plus the per-server group resend bitmaps.
// Assumes the sequencer never marks a refusal and starts an attempt in one cycle.
module isc_state import isc_pkg::*; #(
    parameter int NSRC = 16,
    parameter int NGRP = 2,
    parameter int NSRV = 4,
    parameter int SRCW = 4,
    parameter int GW   = 1,
    parameter int SRVW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SRCW-1:0]   cfg_src,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic [SRVW-1:0]   cfg_server,
    input  logic [SRCW-1:0]   cur,
    input  logic              att_start,
    input  logic              mark_mp,
    input  logic              mark_refused,
    input  logic              rs_req,
    input  logic [SRVW-1:0]   rs_server,
    output logic [PRIO_W-1:0] cur_prio,
    output logic [SRVW-1:0]   cur_server,
    output logic [NSRC-1:0]   resend_vec,
    output logic [NGRP-1:0]   rs_grab,
    output logic              unmask_hit
);
    localparam int SLW = SRCW - GW;

    logic [PRIO_W-1:0] prio_w [NSRC];
    logic [SRVW-1:0]   serv_w [NSRC];
    logic [NSRC-1:0]   mp_w;
    logic [NGRP-1:0]   bm_w [NSRV];
    logic [GW-1:0]     cur_grp;

    assign cur_grp    = cur[SRCW-1:SLW];
    assign cur_prio   = prio_w[cur];
    assign cur_server = serv_w[cur];
    assign rs_grab    = bm_w[rs_server];
    // Unmask of a source that is pending, or is being parked as pending this cycle.
    assign unmask_hit = cfg_we && (cfg_prio != PRIO_MASKED) &&
                        (mp_w[cfg_src] || (mark_mp && (cur == cfg_src)));

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic [PRIO_W-1:0] prio_q;
        logic [SRVW-1:0]   serv_q;
        logic              mp_q, rs_q;
        logic              sel_cfg, sel_cur;

        assign sel_cfg = cfg_we && (cfg_src == SRCW'(i));
        assign sel_cur = (cur == SRCW'(i));

        // Source configuration and its masked-pending / resend flags.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_q <= PRIO_MASKED;
                serv_q <= '0;
                mp_q   <= 1'b0;
                rs_q   <= 1'b0;
            end else begin
                if (sel_cfg) begin
                    prio_q <= cfg_prio;
                    serv_q <= cfg_server;
                end
                if (unmask_hit && sel_cfg)      mp_q <= 1'b0;
                else if (mark_mp && sel_cur)    mp_q <= 1'b1;
                if (att_start && sel_cur)       rs_q <= 1'b0;
                else if (mark_refused && sel_cur) rs_q <= 1'b1;
            end
        end

        assign prio_w[i]     = prio_q;
        assign serv_w[i]     = serv_q;
        assign mp_w[i]       = mp_q;
        assign resend_vec[i] = rs_q;
    end

    for (genvar s = 0; s < NSRV; s++) begin : g_srv
        logic [NGRP-1:0] bm_q, set_v, clr_v;

        assign set_v = (mark_refused && (cur_server == SRVW'(s))) ? (NGRP'(1) << cur_grp) : '0;
        assign clr_v = (rs_req && (rs_server == SRVW'(s))) ? '1 : '0;

        // Group resend bitmap: take-and-clear on request, set on refusal.
        always_ff @(posedge clk) begin
            if (!rst_n) bm_q <= '0;
            else        bm_q <= (bm_q & ~clr_v) | set_v;
        end

        assign bm_w[s] = bm_q;
    end
endmodule

// File: rtl/isc_seq.sv
`timescale 1ns/1ps
// Delivery sequencer: one attempt at a time, queue first, then resend scans.
// Assumes rep_valid is only raised while the sequencer waits for a reply.
module isc_seq import isc_pkg::*; #(
    parameter int NSRC = 16,
    parameter int NGRP = 2,
    parameter int SRCW = 4,
    parameter int GW   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_empty,
    input  logic [SRCW-1:0]   q_dout,
    output logic              q_pop,
    input  logic              rs_req,
    input  logic [NGRP-1:0]   rs_grab,
    input  logic [NSRC-1:0]   resend_vec,
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic              rep_valid,
    input  logic              rep_accept,
    input  logic              rep_need_resend,
    input  logic              rep_disp_valid,
    input  logic              rep_disp_ipi,
    input  logic [SRCW-1:0]   rep_disp_src,
    output logic [SRCW-1:0]   cur,
    output sq_state_t         st,
    output logic              att_start,
    output logic              mark_mp,
    output logic              mark_refused,
    output logic              offer_valid
);
    localparam int SLW = SRCW - GW;

    sq_state_t       st_q;
    logic [SRCW-1:0] cur_q, idx_q;
    logic            in_scan_q;
    logic [NGRP-1:0] smask_q, sact_q;
    logic            hit, idx_last, chase, retry, done, take_scan;

    assign st           = st_q;
    assign cur          = cur_q;
    assign att_start    = (st_q == SQ_ATT);
    assign mark_mp      = att_start && (cur_prio == PRIO_MASKED);
    assign offer_valid  = att_start && !mark_mp;
    assign mark_refused = (st_q == SQ_WAIT) && rep_valid && !rep_accept;
    assign q_pop        = (st_q == SQ_IDLE) && !q_empty;
    assign take_scan    = (st_q == SQ_IDLE) && q_empty && (smask_q != '0);

    assign hit      = sact_q[idx_q[SRCW-1:SLW]] && resend_vec[idx_q];
    assign idx_last = (idx_q == SRCW'(NSRC-1));
    assign chase    = rep_accept && rep_disp_valid && !rep_disp_ipi;
    assign retry    = !rep_accept && !rep_need_resend;
    assign done     = mark_mp || ((st_q == SQ_WAIT) && rep_valid && !chase && !retry);

    // Sequencer state, current source and resend scan bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= SQ_IDLE;
            cur_q     <= '0;
            idx_q     <= '0;
            in_scan_q <= 1'b0;
            smask_q   <= '0;
            sact_q    <= '0;
        end else begin
            smask_q <= (take_scan ? '0 : smask_q) | (rs_req ? rs_grab : '0);
            case (st_q)
                SQ_IDLE: begin
                    if (!q_empty) begin
                        cur_q     <= q_dout;
                        in_scan_q <= 1'b0;
                        st_q      <= SQ_ATT;
                    end else if (take_scan) begin
                        sact_q <= smask_q;
                        idx_q  <= '0;
                        st_q   <= SQ_SCAN;
                    end
                end
                SQ_SCAN: begin
                    if (hit) begin
                        cur_q     <= idx_q;
                        in_scan_q <= 1'b1;
                        st_q      <= SQ_ATT;
                    end else if (idx_last) begin
                        in_scan_q <= 1'b0;
                        st_q      <= SQ_IDLE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                SQ_ATT: begin
                    if (!mark_mp) st_q <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (rep_valid && chase) begin
                        cur_q <= rep_disp_src;
                        st_q  <= SQ_ATT;
                    end else if (rep_valid && retry) begin
                        st_q <= SQ_ATT;
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
            if (done) begin
                if (in_scan_q && !idx_last) begin
                    idx_q <= idx_q + 1'b1;
                    st_q  <= SQ_SCAN;
                end else begin
                    in_scan_q <= 1'b0;
                    st_q      <= SQ_IDLE;
                end
            end
        end
    end
endmodule

// File: rtl/irq_src_bank.sv
`timescale 1ns/1ps
// Interrupt source bank: turns triggers, end-of-interrupt and unmask events
// into presenter offers, and retries refused or displaced sources.
// Assumes at most one of trig_valid, eoi_valid and an unmasking write per cycle.
module irq_src_bank import isc_pkg::*; #(
    parameter int NGRP   = 2,
    parameter int NSLOT  = 8,
    parameter int NSRV   = 4,
    parameter int QDEPTH = 4,
    localparam int NSRC  = NGRP * NSLOT,
    localparam int SRCW  = $clog2(NSRC),
    localparam int GW    = $clog2(NGRP),
    localparam int SRVW  = $clog2(NSRV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SRCW-1:0]   cfg_src,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic [SRVW-1:0]   cfg_server,
    input  logic              trig_valid,
    input  logic [SRCW-1:0]   trig_src,
    input  logic              eoi_valid,
    input  logic [SRCW-1:0]   eoi_src,
    input  logic [NSRC-1:0]   level_in,
    input  logic              rs_req,
    input  logic [SRVW-1:0]   rs_server,
    input  logic              rep_valid,
    input  logic              rep_accept,
    input  logic              rep_need_resend,
    input  logic              rep_disp_valid,
    input  logic              rep_disp_ipi,
    input  logic [SRCW-1:0]   rep_disp_src,
    output logic              offer_valid,
    output logic [SRCW-1:0]   offer_src,
    output logic [PRIO_W-1:0] offer_prio,
    output logic [SRVW-1:0]   offer_server
);
    logic              q_push, q_pop, q_empty, q_full, eoi_hit, unmask_hit;
    logic [SRCW-1:0]   q_din, q_dout, cur;
    logic              att_start, mark_mp, mark_refused;
    logic [PRIO_W-1:0] cur_prio;
    logic [SRVW-1:0]   cur_server;
    logic [NSRC-1:0]   resend_vec;
    logic [NGRP-1:0]   rs_grab;
    sq_state_t         seq_st;

    // Event-to-queue mux: trigger, then still-asserted EOI, then unmask.
    assign eoi_hit = eoi_valid && level_in[eoi_src];
    assign q_push  = trig_valid || eoi_hit || unmask_hit;
    assign q_din   = trig_valid ? trig_src : (eoi_hit ? eoi_src : cfg_src);

    isc_fifo #(.W(SRCW), .DEPTH(QDEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(q_push), .din(q_din),
        .pop(q_pop), .dout(q_dout), .empty(q_empty), .full(q_full)
    );

    isc_state #(.NSRC(NSRC), .NGRP(NGRP), .NSRV(NSRV), .SRCW(SRCW), .GW(GW), .SRVW(SRVW)) u_state (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_prio(cfg_prio), .cfg_server(cfg_server),
        .cur(cur), .att_start(att_start), .mark_mp(mark_mp), .mark_refused(mark_refused),
        .rs_req(rs_req), .rs_server(rs_server),
        .cur_prio(cur_prio), .cur_server(cur_server), .resend_vec(resend_vec),
        .rs_grab(rs_grab), .unmask_hit(unmask_hit)
    );

    isc_seq #(.NSRC(NSRC), .NGRP(NGRP), .SRCW(SRCW), .GW(GW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .q_empty(q_empty), .q_dout(q_dout), .q_pop(q_pop),
        .rs_req(rs_req), .rs_grab(rs_grab), .resend_vec(resend_vec), .cur_prio(cur_prio),
        .rep_valid(rep_valid), .rep_accept(rep_accept), .rep_need_resend(rep_need_resend),
        .rep_disp_valid(rep_disp_valid), .rep_disp_ipi(rep_disp_ipi), .rep_disp_src(rep_disp_src),
        .cur(cur), .st(seq_st), .att_start(att_start), .mark_mp(mark_mp),
        .mark_refused(mark_refused), .offer_valid(offer_valid)
    );

    assign offer_src    = cur;
    assign offer_prio   = cur_prio;
    assign offer_server = cur_server;
endmodule

// File: rtl/isc_chk.sv
`timescale 1ns/1ps
// Protocol and sequencing checks for irq_src_bank, attached by bind.
module isc_chk import isc_pkg::*; #(
    parameter int SRCW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              offer_valid,
    input logic [PRIO_W-1:0] offer_prio,
    input logic              rep_valid,
    input logic              rep_accept,
    input logic              rep_need_resend,
    input logic              rep_disp_valid,
    input logic              rep_disp_ipi,
    input logic [SRCW-1:0]   rep_disp_src,
    input logic [1:0]        st,
    input logic [SRCW-1:0]   cur,
    input logic              q_push,
    input logic              q_full
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !offer_valid);
    // R2
    offer_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |=> !offer_valid);
    // R2
    reply_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid |-> (st == SQ_WAIT));
    // R3
    masked_no_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> (offer_prio != PRIO_MASKED));
    // R6
    retry_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_WAIT && rep_valid && !rep_accept && !rep_need_resend)
        |=> (st == SQ_ATT && cur == $past(cur)));
    // R9
    chase_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_WAIT && rep_valid && rep_accept && rep_disp_valid && !rep_disp_ipi)
        |=> (st == SQ_ATT && cur == $past(rep_disp_src)));
    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |-> !q_full);
endmodule

bind irq_src_bank isc_chk #(.SRCW(SRCW)) u_chk (
    .clk(clk), .rst_n(rst_n), .offer_valid(offer_valid), .offer_prio(offer_prio),
    .rep_valid(rep_valid), .rep_accept(rep_accept), .rep_need_resend(rep_need_resend),
    .rep_disp_valid(rep_disp_valid), .rep_disp_ipi(rep_disp_ipi), .rep_disp_src(rep_disp_src),
    .st(seq_st), .cur(cur), .q_push(q_push), .q_full(q_full)
);

// File: tb/irq_src_bank_bench.sv
`timescale 1ns/1ps
module irq_src_bank_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       cfg_we = 0, trig_valid = 0, eoi_valid = 0, rs_req = 0;
    logic [3:0] cfg_src = 0, trig_src = 0, eoi_src = 0, rep_disp_src = 0, offer_src;
    logic [7:0] cfg_prio = 0, offer_prio;
    logic [1:0] cfg_server = 0, rs_server = 0, offer_server;
    logic [15:0] level_in = 0;
    logic       rep_valid = 0, rep_accept = 0, rep_need_resend = 0, rep_disp_valid = 0, rep_disp_ipi = 0;
    logic       offer_valid;

    irq_src_bank u_irq_src_bank (.*);

    int nchk = 0, nfail = 0;
    typedef struct { bit acc; bit nr; bit dv; bit dipi; int dsrc; } rep_t;
    rep_t rscript[$];
    int olog[$];

    // pending one-shot stimulus
    bit p_rst_n = 0, p_cfg = 0, p_trig = 0, p_eoi = 0, p_rs = 0;
    int p_cfg_src, p_cfg_prio, p_cfg_srv, p_trig_src, p_eoi_src, p_rs_srv;

    // reference model
    int m_prio[16], m_serv[16], m_mp[16], m_res[16], m_bm[4];
    int m_q[$];
    int m_state, m_cur, m_idx, m_inscan, m_smask, m_sact;

    task automatic chk(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin
            m_prio[i] = 255; m_serv[i] = 0; m_mp[i] = 0; m_res[i] = 0;
        end
        for (int s = 0; s < 4; s++) m_bm[s] = 0;
        m_q.delete();
        m_state = 0; m_cur = 0; m_idx = 0; m_inscan = 0; m_smask = 0; m_sact = 0;
    endtask

    task automatic model_step();
        int grab, ns, ncur, nidx, nin, nsact, oldsz, pushsrc, refsrv;
        bit unm, dopush, pop, fin, takesm;
        int attclr, setmp, refused;
        grab = rs_req ? m_bm[rs_server] : 0;
        unm = cfg_we && cfg_prio != 8'hFF && m_mp[cfg_src] != 0;
        dopush = 1; pushsrc = 0;
        if (trig_valid) pushsrc = trig_src;
        else if (eoi_valid && level_in[eoi_src]) pushsrc = eoi_src;
        else if (unm) pushsrc = cfg_src;
        else dopush = 0;
        ns = m_state; ncur = m_cur; nidx = m_idx; nin = m_inscan; nsact = m_sact;
        oldsz = m_q.size();
        takesm = (m_state == 0 && oldsz == 0 && m_smask != 0);
        pop = 0; fin = 0; attclr = -1; setmp = -1; refused = -1;
        refsrv = m_serv[m_cur];
        case (m_state)
            0: if (oldsz > 0) begin pop = 1; ncur = m_q[0]; nin = 0; ns = 2; end
               else if (m_smask != 0) begin nsact = m_smask; nidx = 0; ns = 1; end
            1: if (((m_sact >> (m_idx / 8)) & 1) != 0 && m_res[m_idx] != 0) begin
                   ncur = m_idx; nin = 1; ns = 2;
               end else if (m_idx == 15) begin ns = 0; nin = 0; end
               else nidx = m_idx + 1;
            2: begin
                   attclr = m_cur;
                   if (m_prio[m_cur] == 255) begin setmp = m_cur; fin = 1; end
                   else ns = 3;
               end
            default: if (rep_valid) begin
                   if (rep_accept) begin
                       if (rep_disp_valid && !rep_disp_ipi) begin ncur = rep_disp_src; ns = 2; end
                       else fin = 1;
                   end else begin
                       refused = m_cur;
                       if (rep_need_resend) fin = 1; else ns = 2;
                   end
               end
        endcase
        if (fin) begin
            if (m_inscan != 0 && m_idx != 15) begin nidx = m_idx + 1; ns = 1; end
            else begin nin = 0; ns = 0; end
        end
        if (pop) void'(m_q.pop_front());
        if (dopush && oldsz < 4) m_q.push_back(pushsrc);
        if (cfg_we) begin m_prio[cfg_src] = cfg_prio; m_serv[cfg_src] = cfg_server; end
        if (unm) m_mp[cfg_src] = 0;
        if (setmp >= 0) m_mp[setmp] = 1;
        if (attclr >= 0) m_res[attclr] = 0;
        if (rs_req) m_bm[rs_server] = 0;
        if (refused >= 0) begin
            m_res[refused] = 1;
            m_bm[refsrv] = m_bm[refsrv] | (1 << (refused / 8));
        end
        m_smask = (takesm ? 0 : m_smask) | grab;
        m_state = ns; m_cur = ncur; m_idx = nidx; m_inscan = nin; m_sact = nsact;
    endtask

    task automatic tick();
        bit mov;
        rep_t r;
        @(negedge clk);
        // compare the outputs against the model (R2 fields, every cycle)
        mov = (m_state == 2 && m_prio[m_cur] != 255);
        chk(offer_valid == mov, "R2 offer_valid", offer_valid, mov);
        if (offer_valid && mov) begin
            chk(offer_src == 4'(m_cur), "R2 offer_src", offer_src, m_cur);
            chk(offer_prio == 8'(m_prio[m_cur]), "R2 offer_prio", offer_prio, m_prio[m_cur]);
            chk(offer_server == 2'(m_serv[m_cur]), "R2 offer_server", offer_server, m_serv[m_cur]);
        end
        if (offer_valid) olog.push_back(int'(offer_src));
        // drive the next inputs
        rst_n = p_rst_n;
        cfg_we = p_cfg; cfg_src = 4'(p_cfg_src); cfg_prio = 8'(p_cfg_prio); cfg_server = 2'(p_cfg_srv);
        trig_valid = p_trig; trig_src = 4'(p_trig_src);
        eoi_valid = p_eoi; eoi_src = 4'(p_eoi_src);
        rs_req = p_rs; rs_server = 2'(p_rs_srv);
        rep_valid = 0; rep_accept = 0; rep_need_resend = 0; rep_disp_valid = 0; rep_disp_ipi = 0; rep_disp_src = 0;
        if (rst_n && m_state == 3) begin
            if (rscript.size() > 0) r = rscript.pop_front();
            else begin r.acc = 1; r.nr = 0; r.dv = 0; r.dipi = 0; r.dsrc = 0; end
            rep_valid = 1; rep_accept = r.acc; rep_need_resend = r.nr;
            rep_disp_valid = r.dv; rep_disp_ipi = r.dipi; rep_disp_src = 4'(r.dsrc);
        end
        if (!rst_n) model_reset(); else model_step();
        p_cfg = 0; p_trig = 0; p_eoi = 0; p_rs = 0;
    endtask

    task automatic settle(); for (int i = 0; i < 40; i++) tick(); endtask
    task automatic do_cfg(int s, int p, int v);
        p_cfg = 1; p_cfg_src = s; p_cfg_prio = p; p_cfg_srv = v; tick();
    endtask
    task automatic do_trig(int s); p_trig = 1; p_trig_src = s; tick(); endtask
    task automatic do_eoi(int s); p_eoi = 1; p_eoi_src = s; tick(); endtask
    task automatic do_rs(int v); p_rs = 1; p_rs_srv = v; tick(); endtask
    task automatic push_rep(bit acc, bit nr, bit dv, bit dipi, int dsrc);
        rep_t r; r.acc = acc; r.nr = nr; r.dv = dv; r.dipi = dipi; r.dsrc = dsrc;
        rscript.push_back(r);
    endtask

    task automatic expect_log(string req, int e[$]);
        bit ok;
        int first;
        ok = (olog.size() == e.size());
        first = -1;
        if (ok) foreach (e[k]) if (olog[k] != e[k] && first < 0) first = k;
        if (first >= 0) ok = 0;
        if (!ok && first >= 0) chk(0, req, olog[first], e[first]);
        else chk(ok, req, olog.size(), e.size());
        olog.delete();
    endtask
    task automatic expect_none(string req);
        chk(olog.size() == 0, req, olog.size(), 0);
        olog.delete();
    endtask

    task automatic run_all();
        model_reset();
        for (int i = 0; i < 4; i++) tick();
        chk(offer_valid == 1'b0, "R1 reset no offer", offer_valid, 0);
        p_rst_n = 1; tick();
        // R1: unconfigured source is masked; empty bitmaps
        do_trig(5); settle(); expect_none("R1 default masked");
        do_rs(0); settle(); expect_none("R1 bitmap clear");
        // R2: basic delivery
        do_cfg(3, 5, 1); do_trig(3); settle(); expect_log("R2 basic offer", '{3});
        // R3/R4: masked pending and unmask
        do_trig(9); settle(); expect_none("R3 masked no offer");
        do_cfg(9, 4, 2); settle(); expect_log("R4 unmask delivers", '{9});
        do_cfg(9, 6, 2); settle(); expect_none("R4 no pending no delivery");
        // R5/R7: refusal recorded, resend on matching server only
        do_cfg(10, 7, 2); push_rep(0, 1, 0, 0, 0); do_trig(10); settle();
        expect_log("R5 refused once", '{10});
        do_rs(1); settle(); expect_none("R7 other server empty");
        do_rs(2); settle(); expect_log("R7 resend redelivers", '{10});
        do_rs(2); settle(); expect_none("R7 bitmap test-and-clear");
        // R6/R8: immediate retry, then scan finds no flagged source
        push_rep(0, 0, 0, 0, 0); do_trig(3); settle(); expect_log("R6 immediate retry", '{3, 3});
        do_rs(1); settle(); expect_none("R8 flag cleared at attempt");
        // R9: displacement chasing
        push_rep(1, 0, 1, 0, 10); do_trig(3); settle(); expect_log("R9 displaced chased", '{3, 10});
        push_rep(1, 0, 1, 1, 10); do_trig(3); settle(); expect_log("R9 ipi dropped", '{3});
        // R10: end-of-interrupt with level
        level_in[3] = 1'b1; do_eoi(3); settle(); expect_log("R10 asserted eoi", '{3});
        level_in[3] = 1'b0; do_eoi(3); settle(); expect_none("R10 deasserted eoi");
        // R3: masked between refusal and resend is kept
        do_cfg(11, 8, 2); push_rep(0, 1, 0, 0, 0); do_trig(11); settle();
        expect_log("R5 refused 11", '{11});
        do_cfg(11, 255, 2); do_rs(2); settle(); expect_none("R3 masked resend parked");
        do_cfg(11, 8, 2); settle(); expect_log("R3 masked resend kept", '{11});
        // R11: FIFO order
        do_trig(3); do_trig(10); do_trig(11); settle(); expect_log("R11 fifo order", '{3, 10, 11});
        // R7: multi-source scan ascending
        do_cfg(12, 9, 2); push_rep(0, 1, 0, 0, 0); do_trig(12); settle();
        push_rep(0, 1, 0, 0, 0); do_trig(10); settle(); expect_log("R5 two refusals", '{12, 10});
        do_rs(2); settle(); expect_log("R7 scan ascending", '{10, 12});
    endtask

    initial begin
        bit wd;
        wd = 0;
        fork
            run_all();
            begin repeat (100000) @(posedge clk); wd = 1; end
        join_any
        disable fork;
        if (wd) begin nchk++; nfail++; $display("FAIL watchdog actual=1 expected=0"); end
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule